// File: doc/BRIEF.md
# Linked-Ring Receive Descriptor Engine

This block takes received frames from a byte stream (valid, data, last byte marker and a per-frame error flag vector) and places each one into memory buffers described by a circular, linked list of descriptors. The descriptors and the buffers share one internal word-wide RAM. For each frame, the engine reads the current descriptor to obtain the buffer capacity and the buffer address. It then stores the frame bytes and writes back a command/status word. That word carries the stored size, the ownership flag and the error classification. Finally it follows the link word to the next descriptor.

Ownership works as follows on the receive side. A descriptor whose ownership bit is clear is free for the engine. The engine sets the bit to pass a filled buffer to the host. The host returns the buffer by rewriting the command/status word with the bare capacity. If the next descriptor is still held by the host, the engine stops. While stopped it discards and counts incoming frames until the host issues a receive-on command. A host port gives word access to the RAM, a ring pointer register and a command register with receive-on, receive-off and receive-reset bits.

Descriptor layout, in RAM word addresses relative to a descriptor base D:
- D+0 is the link to the next descriptor base.
- D+1 is the command/status word.
- D+2 is the buffer word address.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset the engine is stopped: `rx_running` is 0, `drop_count` is 0 and a read of the ring pointer register (host_sel 2'b01) returns 0.
- R2: Byte k of a frame is stored in RAM word (buffer address + k/4), byte lane k%4, where lane L occupies bits 8L+7 down to 8L.
- R3: At the end of a frame the command/status word at D+1 is written with bit 31 (owned by host) set, bit 30 clear, and the stored byte count in bits 11:0. The count includes the 4 trailing CRC bytes of the stream. Bit 27 (frame good) is set only when none of the CRC, alignment, invalid-symbol or runt flags is set and the frame is not too long.
- R4: The capacity is taken from bits 11:0 of the command/status word when the descriptor is fetched. Bytes beyond the capacity are not written. Such a frame gets bit 22 (too long) set and reports a size equal to the capacity.
- R5: The rx_flags inputs at the last byte map to status bits as follows: [0] CRC error to 19, [1] alignment to 18, [2] invalid symbol to 20, [3] runt to 21, [4] collision to 16, [5] loopback to 17, [7:6] destination class to 24:23. Bits 26 and 25 stay 0.
- R6: After the status writeback completes, the next frame goes to the descriptor named by the link word at D+0.
- R7: If the fetched descriptor has bit 31 set, the engine stops (`rx_running` 0). Each frame that starts while the engine is not ready is discarded without touching RAM and increments `drop_count` by one.
- R8: Writing the command register (host_sel 2'b10) with bit 2 set while stopped makes the engine re-fetch the descriptor where it stopped and resume.
- R9: Command bit 3 stops the engine. A frame already being stored is completed and written back first. Later frames are dropped and counted.
- R10: Command bit 5 stops the engine, clears `drop_count` and reloads the current descriptor from the last value written to the ring pointer register.
- R11: A write to the ring pointer register sets the current descriptor. A read of it returns the current descriptor base.
- R12: A host read (host_rd) of RAM (host_sel 2'b00) or of the pointer returns its data on `host_rdata` one clock after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_flags | input | 8 | Error and class flags, sampled with the last byte |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 2 | 00 RAM, 01 ring pointer, 10 command |
| host_addr | input | AW | RAM word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| rx_running | output | 1 | Engine is fetching or receiving |
| drop_count | output | DCW | Count of discarded frames |

## Verification
The writeback of a frame lands one clock after its last byte. The engine reaches its next descriptor two clocks later. The bench therefore waits four falling edges after each frame before reading results through the host port, and a host read is sampled on the falling edge after the edge that registers it. After a receive-on command, the fetch takes two clocks, so the bench waits two further edges before the next frame. Drop counts and `rx_running` are sampled in that same settled window, after the engine has either stopped or become ready.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [2:0] {
        ST_HALT  = 3'd0,
        ST_FETCH = 3'd1,
        ST_READY = 3'd2,
        ST_RECV  = 3'd3,
        ST_WB    = 3'd4
    } rxr_state_e;

    localparam logic [1:0] SEL_RAM = 2'b00;
    localparam logic [1:0] SEL_PTR = 2'b01;
    localparam logic [1:0] SEL_CMD = 2'b10;

    localparam int CMD_ON  = 2;
    localparam int CMD_OFF = 3;
    localparam int CMD_RST = 5;

    localparam int B_HOST = 31;
    localparam int B_MORE = 30;
    localparam int B_GOOD = 27;
    localparam int B_LONG = 22;
endpackage

// File: rtl/rxr_mem.sv
module rxr_mem #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    input  logic          eng_we,
    input  logic [3:0]    eng_be,
    input  logic [AW-1:0] eng_waddr,
    input  logic [31:0]   eng_wdata,
    input  logic [AW-1:0] eng_raddr0,
    input  logic [AW-1:0] eng_raddr1,
    output logic [31:0]   eng_rdata0,
    output logic [31:0]   eng_rdata1
);
    localparam int DEPTH = 1 << AW;

    logic [31:0] mem [DEPTH];

    // Engine lanes are applied after the host word, so the engine wins a clash.
    always_ff @(posedge clk) begin
        if (host_we) mem[host_addr] <= host_wdata;
        for (int l = 0; l < 4; l++) begin
            if (eng_we && eng_be[l]) mem[eng_waddr][8*l +: 8] <= eng_wdata[8*l +: 8];
        end
    end

    assign host_rdata = mem[host_addr];
    assign eng_rdata0 = mem[eng_raddr0];
    assign eng_rdata1 = mem[eng_raddr1];
endmodule

// File: rtl/rxr_status.sv
module rxr_status #(
    parameter int SW = 12
) (
    input  logic [7:0]    flags,
    input  logic          too_long,
    input  logic [SW-1:0] size,
    output logic [31:0]   word
);
    import rxr_pkg::*;

    logic bad;
    assign bad = flags[0] | flags[1] | flags[2] | flags[3] | too_long;

    always_comb begin
        word           = '0;
        word[SW-1:0]   = size;
        word[16]       = flags[4];
        word[17]       = flags[5];
        word[18]       = flags[1];
        word[19]       = flags[0];
        word[20]       = flags[2];
        word[21]       = flags[3];
        word[B_LONG]   = too_long;
        word[24:23]    = flags[7:6];
        word[B_GOOD]   = !bad;
        word[B_HOST]   = 1'b1;
    end
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
    import rxr_pkg::*;
#(
    parameter int AW  = 8,
    parameter int SW  = 12,
    parameter int DCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_valid,
    input  logic [7:0]     rx_data,
    input  logic           rx_last,
    input  logic [7:0]     rx_flags,
    input  logic           host_wr,
    input  logic           host_rd,
    input  logic [1:0]     host_sel,
    input  logic [AW-1:0]  host_addr,
    input  logic [31:0]    host_wdata,
    output logic [31:0]    host_rdata,
    output logic           rx_running,
    output logic [DCW-1:0] drop_count
);
    localparam logic [AW-1:0] OFS_CS  = AW'(1);
    localparam logic [AW-1:0] OFS_BUF = AW'(2);

    typedef struct packed {
        rxr_state_e     st;
        logic [AW-1:0]  cur;
        logic [AW-1:0]  base;
        logic [AW-1:0]  bufp;
        logic [SW-1:0]  cap;
        logic [SW-1:0]  cnt;
        logic           too_long;
        logic           off_pend;
        logic           dropping;
        logic           in_frame;
        logic [7:0]     flags;
        logic [DCW-1:0] drops;
        logic [31:0]    rdata;
    } ring_t;

    ring_t d, q;

    logic          eng_we;
    logic [3:0]    eng_be;
    logic [AW-1:0] eng_waddr, eng_raddr0, eng_raddr1;
    logic [31:0]   eng_wdata, eng_rdata0, eng_rdata1, mem_hrdata, wb_word;
    logic          rx_start, take, cmd_wr, unused_bits;
    logic [SW-1:0] idx;

    rxr_mem #(.AW(AW)) u_mem (
        .clk(clk), .host_we(host_wr && host_sel == SEL_RAM), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(mem_hrdata),
        .eng_we(eng_we), .eng_be(eng_be), .eng_waddr(eng_waddr), .eng_wdata(eng_wdata),
        .eng_raddr0(eng_raddr0), .eng_raddr1(eng_raddr1),
        .eng_rdata0(eng_rdata0), .eng_rdata1(eng_rdata1)
    );

    rxr_status #(.SW(SW)) u_stat (
        .flags(q.flags), .too_long(q.too_long), .size(q.cnt), .word(wb_word)
    );

    assign unused_bits = ^{eng_rdata0, eng_rdata1};
    assign cmd_wr      = host_wr && host_sel == SEL_CMD;

    always_comb begin
        d          = q;
        eng_we     = 1'b0;
        eng_be     = '0;
        eng_waddr  = q.cur;
        eng_wdata  = {4{rx_data}};
        eng_raddr0 = q.cur + OFS_CS;
        eng_raddr1 = q.cur + OFS_BUF;

        // frame framing and discard tracking
        rx_start = rx_valid && !q.in_frame;
        if (rx_valid) d.in_frame = !rx_last;
        if (rx_start && q.st != ST_READY) begin
            d.drops    = q.drops + 1'b1;
            d.dropping = !rx_last;
        end else if (q.dropping && rx_valid && rx_last) begin
            d.dropping = 1'b0;
        end

        case (q.st)
            ST_FETCH: begin
                if (eng_rdata0[B_HOST]) begin
                    d.st = ST_HALT;
                end else begin
                    d.cap  = eng_rdata0[SW-1:0];
                    d.bufp = eng_rdata1[AW-1:0];
                    d.st   = ST_READY;
                end
            end
            ST_WB: begin
                eng_we     = 1'b1;
                eng_be     = 4'hF;
                eng_waddr  = q.cur + OFS_CS;
                eng_wdata  = wb_word;
                eng_raddr0 = q.cur;
                d.cur      = eng_rdata0[AW-1:0];
                d.st       = q.off_pend ? ST_HALT : ST_FETCH;
                d.off_pend = 1'b0;
            end
            default: ;
        endcase

        // byte storage
        take = rx_valid && !q.dropping &&
               ((q.st == ST_READY && rx_start) || q.st == ST_RECV);
        idx  = (q.st == ST_READY) ? '0 : q.cnt;
        if (take) begin
            d.too_long = (q.st == ST_READY) ? 1'b0 : q.too_long;
            d.cnt      = idx;
            if (idx < q.cap) begin
                eng_we    = 1'b1;
                eng_be    = 4'b0001 << idx[1:0];
                eng_waddr = q.bufp + AW'(idx >> 2);
                d.cnt     = idx + 1'b1;
            end else begin
                d.too_long = 1'b1;
            end
            if (rx_last) begin
                d.st    = ST_WB;
                d.flags = rx_flags;
            end else begin
                d.st = ST_RECV;
            end
        end

        // host registers and commands
        if (host_wr && host_sel == SEL_PTR) begin
            d.base = host_wdata[AW-1:0];
            d.cur  = host_wdata[AW-1:0];
        end
        if (cmd_wr) begin
            if (host_wdata[CMD_ON] && q.st == ST_HALT) d.st = ST_FETCH;
            if (host_wdata[CMD_OFF]) begin
                if (d.st == ST_RECV || d.st == ST_WB) d.off_pend = 1'b1;
                else                                   d.st       = ST_HALT;
            end
            if (host_wdata[CMD_RST]) begin
                d.st       = ST_HALT;
                d.cur      = q.base;
                d.drops    = '0;
                d.off_pend = 1'b0;
                d.cnt      = '0;
                d.too_long = 1'b0;
            end
        end

        if (host_rd) begin
            case (host_sel)
                SEL_RAM: d.rdata = mem_hrdata;
                SEL_PTR: d.rdata = 32'(q.cur);
                default: d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign host_rdata = q.rdata;
    assign rx_running = q.st != ST_HALT;
    assign drop_count = q.drops;
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker
    import rxr_pkg::*;
#(
    parameter int SW  = 12,
    parameter int DCW = 16
) (
    input logic           clk,
    input logic           rst_n,
    input rxr_state_e     st,
    input logic           eng_we,
    input logic [3:0]     eng_be,
    input logic [31:0]    eng_wdata,
    input logic [SW-1:0]  cap,
    input logic [DCW-1:0] drops
);
    // R7: a stopped engine leaves the RAM alone
    a_r7_halt_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT) |-> !eng_we);

    // R3: every status writeback hands the buffer to the host with More clear
    a_r3_wb_owned: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && eng_be == 4'hF) |-> (eng_wdata[B_HOST] && !eng_wdata[B_MORE]));

    // R4: reported size never exceeds the fetched capacity
    a_r4_size_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && eng_be == 4'hF) |-> (eng_wdata[SW-1:0] <= cap));

    // R2: data stores touch exactly one byte lane
    a_r2_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && eng_be != 4'hF) |-> ($countones(eng_be) == 1));

    // R6: after writeback the engine fetches the linked descriptor or stops
    a_r6_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WB) |=> (st == ST_FETCH || st == ST_HALT));

    // R7 R10: the drop counter steps by one or clears
    a_r7_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (drops == $past(drops) || drops == $past(drops) + 1'b1 || drops == '0));
endmodule

bind rx_desc_ring rxr_checker #(.SW(SW), .DCW(DCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(q.st), .eng_we(eng_we), .eng_be(eng_be),
    .eng_wdata(eng_wdata), .cap(q.cap), .drops(q.drops)
);

// File: tb/sim_rx_desc_ring.sv
`timescale 1ns/1ps
module sim_rx_desc_ring;
    localparam int AW = 8;
    localparam int ND = 3;
    localparam int CAP = 64;

    logic        clk = 0, rst_n = 0;
    logic        rx_valid = 0, rx_last = 0;
    logic [7:0]  rx_data = 0, rx_flags = 0;
    logic        host_wr = 0, host_rd = 0;
    logic [1:0]  host_sel = 0;
    logic [AW-1:0] host_addr = 0;
    logic [31:0] host_wdata = 0, host_rdata;
    logic        rx_running;
    logic [15:0] drop_count;

    rx_desc_ring #(.AW(AW)) u0 (.*);

    always #2 clk = ~clk;

    int checks = 0, fails = 0;
    logic [7:0] fb [0:127];
    bit   owned [ND];
    logic [31:0] memval [ND];
    int   cur_i = 0, ret_i = 0, drops_exp = 0;
    bit   halted = 1;

    function automatic int dbase(int i); return 4 + 4 * i; endfunction
    function automatic int bbase(int i); return 32 + 16 * i; endfunction

    function automatic logic [31:0] exp_status(int len, logic [7:0] f);
        logic [31:0] w = '0;
        int n = (len > CAP) ? CAP : len;
        bit lng = len > CAP;
        w[11:0] = 12'(n);
        w[31] = 1'b1;
        w[22] = lng;
        w[19] = f[0]; w[18] = f[1]; w[20] = f[2]; w[21] = f[3];
        w[16] = f[4]; w[17] = f[5]; w[24:23] = f[7:6];
        w[27] = !(f[0] | f[1] | f[2] | f[3] | lng);
        return w;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(logic [1:0] sel, int addr, logic [31:0] data);
        @(negedge clk);
        host_wr = 1; host_sel = sel; host_addr = AW'(addr); host_wdata = data;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic hread(logic [1:0] sel, int addr, output logic [31:0] data);
        @(negedge clk);
        host_rd = 1; host_sel = sel; host_addr = AW'(addr);
        @(negedge clk);
        host_rd = 0;
        data = host_rdata;
    endtask

    task automatic rx_on();
        hwrite(2'b10, 0, 32'h4);
        repeat (2) @(negedge clk);
    endtask

    task automatic send(int len, logic [7:0] f);
        for (int k = 0; k < len; k++) fb[k] = 8'($urandom);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rx_valid = 1; rx_data = fb[k]; rx_last = (k == len - 1); rx_flags = f;
        end
        @(negedge clk);
        rx_valid = 0; rx_last = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame(int len, logic [7:0] f);
        logic [31:0] rd, e;
        int n, bad;
        send(len, f);
        if (halted) begin
            drops_exp++;
            check(drop_count == 16'(drops_exp), "R7 drop count", 32'(drop_count), 32'(drops_exp));
            hread(2'b00, dbase(cur_i) + 1, rd);
            check(rd == memval[cur_i], "R7 descriptor untouched", rd, memval[cur_i]);
        end else begin
            e = exp_status(len, f);
            hread(2'b00, dbase(cur_i) + 1, rd);
            check(rd == e, "R3 R4 R5 R6 status word", rd, e);
            n = (len > CAP) ? CAP : len;
            bad = 0;
            for (int w = 0; w < (n + 3) / 4; w++) begin
                hread(2'b00, bbase(cur_i) + w, rd);
                for (int l = 0; l < 4; l++)
                    if (w * 4 + l < n && rd[8*l +: 8] != fb[w*4+l]) bad++;
            end
            check(bad == 0, "R2 R4 buffer bytes", 32'(bad), 32'd0);
            memval[cur_i] = e;
            owned[cur_i] = 1;
            cur_i = (cur_i + 1) % ND;
            if (owned[cur_i]) halted = 1;
        end
        check(rx_running == !halted, "R7 running state", 32'(rx_running), 32'(!halted));
    endtask

    task automatic give_back();
        if (owned[ret_i]) begin
            hwrite(2'b00, dbase(ret_i) + 1, CAP);
            memval[ret_i] = CAP;
            owned[ret_i] = 0;
            ret_i = (ret_i + 1) % ND;
        end
        if (halted && !owned[cur_i]) begin
            rx_on();
            halted = 0;
            check(rx_running == 1'b1, "R8 resume", 32'(rx_running), 32'd1);
        end
    endtask

    task automatic init_ring();
        for (int i = 0; i < ND; i++) begin
            hwrite(2'b00, dbase(i), dbase((i + 1) % ND));
            hwrite(2'b00, dbase(i) + 1, CAP);
            hwrite(2'b00, dbase(i) + 2, bbase(i));
            owned[i] = 0; memval[i] = CAP;
        end
        cur_i = 0; ret_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(rx_running == 1'b0, "R1 running", 32'(rx_running), 32'd0);
        check(drop_count == 0, "R1 drop count", 32'(drop_count), 32'd0);
        hread(2'b01, 0, rd);
        check(rd == 0, "R1 R12 pointer", rd, 32'd0);

        init_ring();
        hwrite(2'b01, 0, dbase(0));
        hread(2'b01, 0, rd);
        check(rd == 32'(dbase(0)), "R11 pointer readback", rd, 32'(dbase(0)));
        hread(2'b00, dbase(0) + 2, rd);
        check(rd == 32'(bbase(0)), "R12 ram readback", rd, 32'(bbase(0)));

        frame(10, 8'h00);             // stopped from reset: dropped (R7)
        rx_on(); halted = 0;
        frame(CAP, 8'h00);            // exactly capacity (R4)
        give_back();
        frame(CAP + 1, 8'h00);        // one byte too many (R4)
        give_back();
        frame(1, 8'h00);              // single byte
        give_back();
        frame(20, 8'hFF);             // every flag (R5)
        give_back();
        frame(8, 8'h41);              // CRC error plus class (R5)
        give_back();

        for (int t = 0; t < 40; t++) begin
            logic [7:0] f = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
            frame(1 + int'($urandom % 70), f);
            if ($urandom % 2 == 0) give_back();
        end
        while (owned[ret_i]) give_back();
        if (halted) give_back();

        // receive off (R9)
        hwrite(2'b10, 0, 32'h8);
        halted = 1;
        check(rx_running == 1'b0, "R9 stopped", 32'(rx_running), 32'd0);
        frame(12, 8'h00);
        rx_on(); halted = owned[cur_i];
        frame(12, 8'h00);
        give_back();

        // receive reset (R10)
        hwrite(2'b10, 0, 32'h20);
        @(negedge clk);
        drops_exp = 0;
        check(drop_count == 0, "R10 drop count cleared", 32'(drop_count), 32'd0);
        check(rx_running == 1'b0, "R10 stopped", 32'(rx_running), 32'd0);
        hread(2'b01, 0, rd);
        check(rd == 32'(dbase(0)), "R10 R11 pointer reloaded", rd, 32'(dbase(0)));
        init_ring();
        rx_on(); halted = 0;
        frame(16, 8'h00);             // lands in descriptor 0 (R10)

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule